// File: doc/BRIEF.md
# Tear-Check Scanline Predictor

A command-mode panel refreshes from its own frame memory and does not report where it is reading. This block estimates that position. It divides a slow reference clock (nominally 19.2 MHz) into line periods and steps a scanline counter once per period. It then raises events at programmed lines. Software picks the ticks-per-line value as the reference rate divided by the product of vertical total and refresh rate, using integer division. It sets the counter height to twice the vertical total. With that setting, the wrap event serves as a fallback frame sync at about half the refresh rate.

When counting begins, and on each resynchronisation, the counter loads a programmed initial line, normally the active line count. A read-pointer event fires on a chosen line, normally one past the active region. A frame-start event fires on the start line, but only if the read-pointer line lies within a window just after the start line. An optional tear-effect input from the panel can realign the counter. All logic runs in the reference clock domain. Every event is a single-cycle registered pulse that appears in the same cycle as the line count it refers to.

Top module: `tc_scanline`

## Requirements
- R1: After reset, all pulse outputs are 0 and the line count is 0.
- R2: The block counts only while the master enable, the count enable and a nonzero ticks-per-line value are all present. Otherwise the line count reads 0 and no pulse is emitted.
- R3: One cycle after counting becomes allowed, the line count equals the initial line and no line tick is shown. After that, a line tick pulse appears every ticks-per-line cycles, and the count advances by one with each tick.
- R4: After line height−1 the count wraps to 0, and the wrap is marked by a blank pulse. The blank period is therefore ticks-per-line × height cycles.
- R5: The read-pointer pulse accompanies the tick on which the count becomes equal to the read-pointer line.
- R6: The frame-start pulse accompanies the tick on which the count becomes equal to the start line. It fires only if the read-pointer line is not below the start line and exceeds it by at most the start threshold.
- R7: With sync input enabled, a rising edge on the tear-effect input, registered once, reloads the initial line and restarts the line period. On that cycle no tick is emitted, and this takes priority over a tick due in the same cycle.
- R8: With sync input disabled, the tear-effect input has no effect on the count or on the pulses.
- R9: Clearing the master enable returns the count to 0 and silences every pulse from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tc_en_i | input | 1 | Master enable for the whole block |
| cnt_en_i | input | 1 | Counter enable |
| sync_en_i | input | 1 | Allows the tear-effect input to resynchronise |
| ticks_per_line_i | input | TPL_W | Reference cycles per line; 0 blocks counting |
| height_i | input | LINE_W | Wrap height in lines |
| init_line_i | input | LINE_W | Line loaded at start and on resync |
| rdptr_line_i | input | LINE_W | Line that raises the read-pointer pulse |
| start_line_i | input | LINE_W | Line that may raise the frame-start pulse |
| start_win_i | input | LINE_W | Frame-start threshold in lines |
| te_i | input | 1 | Panel tear-effect input |
| line_tick_o | output | 1 | One pulse per line advance |
| line_cnt_o | output | LINE_W | Current predicted scanline |
| rdptr_irq_o | output | 1 | Read-pointer pulse |
| frame_start_o | output | 1 | Frame-start pulse |
| blank_o | output | 1 | Wrap (synthetic vsync) pulse |

## Verification
The assertions assume that the configuration inputs do not change while counting is allowed, or within two cycles after it stops. They also assume that the initial line is below the height. The bench drops the count enable and waits two cycles before each reprogramming. It only loads initial lines from 0 to height−1. It sweeps ticks-per-line, height, initial line and start threshold across a small grid, and it predicts each cycle's count and pulses from the number of cycles since the load.

// File: rtl/tc_pkg.sv
package tc_pkg;
  typedef enum logic {ST_IDLE = 1'b0, ST_RUN = 1'b1} run_state_e;
endpackage

// File: rtl/tc_tick_div.sv
module tc_tick_div #(
  parameter int TPL_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             clr_i,
  input  logic [TPL_W-1:0] tpl_i,
  output logic             wrap_o
);
  logic [TPL_W-1:0] div_q;

  assign wrap_o = run_i && !clr_i && (div_q == tpl_i - 1'b1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     div_q <= '0;
    else if (!run_i || clr_i || wrap_o) div_q <= '0;
    else                             div_q <= div_q + 1'b1;
  end

  // config held static while running
  p_div_bound_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |-> (div_q < tpl_i));
endmodule

// File: rtl/tc_line_ctr.sv
module tc_line_ctr #(
  parameter int LINE_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              active_i,
  input  logic              load_i,
  input  logic              step_i,
  input  logic [LINE_W-1:0] height_i,
  input  logic [LINE_W-1:0] init_i,
  output logic [LINE_W-1:0] line_o,
  output logic [LINE_W-1:0] line_nxt_o,
  output logic              wrap_o
);
  localparam int CW = LINE_W + 1;

  logic [LINE_W-1:0] line_q;
  logic [CW-1:0]     inc;

  assign inc        = {1'b0, line_q} + 1'b1;
  assign wrap_o     = inc >= {1'b0, height_i};
  assign line_nxt_o = wrap_o ? '0 : inc[LINE_W-1:0];
  assign line_o     = line_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        line_q <= '0;
    else if (!active_i) line_q <= '0;
    else if (load_i)    line_q <= init_i;
    else if (step_i)    line_q <= line_nxt_o;
  end

  p_idle_zero_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active_i |=> (line_q == '0));
  p_line_bound_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_i && step_i) |=> (line_q < height_i));
endmodule

// File: rtl/tc_evt_gen.sv
module tc_evt_gen #(
  parameter int LINE_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              step_i,
  input  logic              wrap_i,
  input  logic [LINE_W-1:0] line_nxt_i,
  input  logic [LINE_W-1:0] rdptr_i,
  input  logic [LINE_W-1:0] start_i,
  input  logic [LINE_W-1:0] win_i,
  output logic              tick_o,
  output logic              irq_o,
  output logic              fs_o,
  output logic              blank_o
);
  logic in_win;
  logic tick_q, irq_q, fs_q, blank_q;

  // read pointer must sit at or just after the start line
  assign in_win = (rdptr_i >= start_i) && ((rdptr_i - start_i) <= win_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tick_q  <= 1'b0;
      irq_q   <= 1'b0;
      fs_q    <= 1'b0;
      blank_q <= 1'b0;
    end else begin
      tick_q  <= step_i;
      irq_q   <= step_i && (line_nxt_i == rdptr_i);
      fs_q    <= step_i && (line_nxt_i == start_i) && in_win;
      blank_q <= step_i && wrap_i;
    end
  end

  assign tick_o  = tick_q;
  assign irq_o   = irq_q;
  assign fs_o    = fs_q;
  assign blank_o = blank_q;

  p_fs_on_tick_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fs_q |-> tick_q);
  p_blank_on_tick_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    blank_q |-> tick_q);
endmodule

// File: rtl/tc_scanline.sv
module tc_scanline #(
  parameter int TPL_W   = 16,
  parameter int LINE_W  = 12,
  parameter int TE_SYNC = 0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tc_en_i,
  input  logic              cnt_en_i,
  input  logic              sync_en_i,
  input  logic [TPL_W-1:0]  ticks_per_line_i,
  input  logic [LINE_W-1:0] height_i,
  input  logic [LINE_W-1:0] init_line_i,
  input  logic [LINE_W-1:0] rdptr_line_i,
  input  logic [LINE_W-1:0] start_line_i,
  input  logic [LINE_W-1:0] start_win_i,
  input  logic              te_i,
  output logic              line_tick_o,
  output logic [LINE_W-1:0] line_cnt_o,
  output logic              rdptr_irq_o,
  output logic              frame_start_o,
  output logic              blank_o
);
  import tc_pkg::*;

  run_state_e        state_q;
  logic              active, start, run, resync, step, wrap;
  logic              te_s, te_q, te_rise;
  logic [LINE_W-1:0] line_nxt;

  generate
    if (TE_SYNC == 0) begin : g_te_direct
      assign te_s = te_i;
    end else begin : g_te_sync
      logic [TE_SYNC-1:0] sync_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q <= '0;
        else         sync_q <= {sync_q[TE_SYNC-2+((TE_SYNC==1)?1:0):0], te_i};
      end
      assign te_s = sync_q[TE_SYNC-1];
    end
  endgenerate

  assign active  = tc_en_i && cnt_en_i && (ticks_per_line_i != '0);
  assign start   = active && (state_q == ST_IDLE);
  assign run     = active && (state_q == ST_RUN);
  assign te_rise = te_s && !te_q;
  assign resync  = run && sync_en_i && te_rise;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      te_q    <= 1'b0;
    end else begin
      state_q <= active ? ST_RUN : ST_IDLE;
      te_q    <= te_s;
    end
  end

  tc_tick_div #(.TPL_W(TPL_W)) u_div (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (run),
    .clr_i  (resync),
    .tpl_i  (ticks_per_line_i),
    .wrap_o (step)
  );

  tc_line_ctr #(.LINE_W(LINE_W)) u_line (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .active_i   (active),
    .load_i     (start || resync),
    .step_i     (step),
    .height_i   (height_i),
    .init_i     (init_line_i),
    .line_o     (line_cnt_o),
    .line_nxt_o (line_nxt),
    .wrap_o     (wrap)
  );

  tc_evt_gen #(.LINE_W(LINE_W)) u_evt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .step_i     (step),
    .wrap_i     (wrap),
    .line_nxt_i (line_nxt),
    .rdptr_i    (rdptr_line_i),
    .start_i    (start_line_i),
    .win_i      (start_win_i),
    .tick_o     (line_tick_o),
    .irq_o      (rdptr_irq_o),
    .fs_o       (frame_start_o),
    .blank_o    (blank_o)
  );

  p_blank_zero_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    blank_o |-> (line_cnt_o == '0));
  p_irq_match_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdptr_irq_o |-> (line_cnt_o == rdptr_line_i));
  p_fs_match_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_start_o |-> (line_cnt_o == start_line_i));
  p_resync_load_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resync |=> (line_cnt_o == $past(init_line_i)) && !line_tick_o);
  p_off_quiet_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tc_en_i |=> !(line_tick_o || rdptr_irq_o || frame_start_o || blank_o));
  p_start_loads_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start |=> (line_cnt_o == $past(init_line_i)) && !line_tick_o);
endmodule

// File: tb/tc_scanline_test.sv
module tc_scanline_test;
  localparam int CLK_PERIOD = 10;
  localparam int TPL_W  = 16;
  localparam int LINE_W = 12;

  logic              clk = 1'b0;
  logic              rst_ni = 1'b0;
  logic              tc_en = 1'b0, cnt_en = 1'b0, sync_en = 1'b0, te = 1'b0;
  logic [TPL_W-1:0]  tpl = '0;
  logic [LINE_W-1:0] height = '0, init_line = '0, rdptr = '0, start_line = '0, win = '0;
  logic              tick, irq, fs, blank;
  logic [LINE_W-1:0] line;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tc_scanline #(.TPL_W(TPL_W), .LINE_W(LINE_W)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .tc_en_i(tc_en), .cnt_en_i(cnt_en),
    .sync_en_i(sync_en), .ticks_per_line_i(tpl), .height_i(height),
    .init_line_i(init_line), .rdptr_line_i(rdptr), .start_line_i(start_line),
    .start_win_i(win), .te_i(te), .line_tick_o(tick), .line_cnt_o(line),
    .rdptr_irq_o(irq), .frame_start_o(fs), .blank_o(blank)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  task automatic quiet(input string req);
    chk(line == 0, req, int'(line), 0);
    chk({tick, irq, fs, blank} == 4'b0, req, int'({tick, irq, fs, blank}), 0);
  endtask

  // ends at the negedge where the initial line is loaded (k = 0)
  task automatic restart(input int t, input int h, input int i0, input int rd,
                         input int sp, input int th);
    cnt_en = 1'b0;
    repeat (2) @(negedge clk);
    tpl = TPL_W'(t); height = LINE_W'(h); init_line = LINE_W'(i0);
    rdptr = LINE_W'(rd); start_line = LINE_W'(sp); win = LINE_W'(th);
    @(negedge clk);
    cnt_en = 1'b1;
    @(negedge clk);
  endtask

  // expected outputs k cycles after load with base line b
  task automatic expect_k(input int k, input int t, input int h, input int b,
                          input int rd, input int sp, input int th);
    int  el;
    bit  et, eb, ei, ef;
    el = (b + k / t) % h;
    et = (k > 0) && (k % t == 0);
    eb = et && (el == 0);
    ei = et && (el == rd);
    ef = et && (el == sp) && (rd >= sp) && (rd - sp <= th);
    chk(int'(line) == el, "R3 line count", int'(line), el);
    chk(tick == et, "R3 line tick", int'(tick), int'(et));
    chk(blank == eb, "R4 blank on wrap", int'(blank), int'(eb));
    chk(irq == ei, "R5 read-pointer pulse", int'(irq), int'(ei));
    chk(fs == ef, "R6 frame-start pulse", int'(fs), int'(ef));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    quiet("R1 reset");
    rst_ni = 1'b1;
    @(negedge clk);
    quiet("R1 after reset");

    // R2: zero ticks-per-line, and missing master enable
    tc_en = 1'b1; cnt_en = 1'b1; tpl = '0; height = 12'd4; init_line = 12'd2;
    repeat (6) begin @(negedge clk); quiet("R2 zero ticks-per-line"); end
    cnt_en = 1'b0; @(negedge clk); @(negedge clk);
    tc_en = 1'b0; tpl = 16'd1; cnt_en = 1'b1;
    repeat (6) begin @(negedge clk); quiet("R2 master enable off"); end
    tc_en = 1'b1;

    // R3..R6 sweep
    for (int t = 1; t <= 3; t++)
      for (int hi = 0; hi < 3; hi++)
        for (int ii = 0; ii < 2; ii++)
          for (int th = 0; th < 2; th++) begin
            int h, i0, rd, sp;
            h  = (hi == 0) ? 2 : (hi == 1) ? 3 : 5;
            i0 = (ii == 0) ? 0 : h - 1;
            rd = h - 1;
            sp = h - 2;
            restart(t, h, i0, rd, sp, th);
            chk(int'(line) == i0, "R3 initial load", int'(line), i0);
            chk(tick == 1'b0, "R3 no tick on load", int'(tick), 0);
            for (int k = 1; k <= 2 * h * t + 2; k++) begin
              @(negedge clk);
              expect_k(k, t, h, i0, rd, sp, th);
            end
          end

    // R6: read pointer below start line never qualifies
    restart(1, 6, 0, 2, 4, 5);
    for (int k = 1; k <= 12; k++) begin
      @(negedge clk);
      expect_k(k, 1, 6, 0, 2, 4, 5);
    end

    // R7: resync on tear-effect rising edge
    sync_en = 1'b1; te = 1'b0;
    restart(2, 8, 3, 7, 6, 1);
    for (int k = 1; k <= 5; k++) begin @(negedge clk); expect_k(k, 2, 8, 3, 7, 6, 1); end
    te = 1'b1;  // tick due at k=6 is overridden
    @(negedge clk);
    chk(int'(line) == 3, "R7 resync reload", int'(line), 3);
    chk(tick == 1'b0, "R7 resync suppresses tick", int'(tick), 0);
    for (int k = 1; k <= 6; k++) begin @(negedge clk); expect_k(k, 2, 8, 3, 7, 6, 1); end
    te = 1'b0;

    // R8: edge ignored when sync input disabled
    sync_en = 1'b0;
    restart(2, 8, 1, 7, 6, 1);
    for (int k = 1; k <= 10; k++) begin
      te = (k == 4);
      @(negedge clk);
      expect_k(k, 2, 8, 1, 7, 6, 1);
    end
    te = 1'b0;

    // R9: master enable cleared mid-run
    restart(1, 5, 0, 4, 3, 1);
    for (int k = 1; k <= 3; k++) begin @(negedge clk); expect_k(k, 1, 5, 0, 4, 3, 1); end
    tc_en = 1'b0;
    repeat (4) begin @(negedge clk); quiet("R9 disabled"); end

    finish_run();
  end
endmodule